// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Takeover

This block is one general-purpose I/O port of eight pins. Software sets each pin's direction, driven level and pull-up through three writable registers on a small register bus. It reads the pin levels back through a fourth register that is fed by a synchronizer. The block drives the pad controls: output enable, output level and pull-up enable. It also gates the pad input and passes that input on to peripherals.

Any peripheral sharing a pin can take over that pin's controls one at a time. Four enable/value pairs cover the pull-up, the driver enable, the driven level and the digital input enable. A set enable replaces the register bit or core state with the paired value. A fifth per-pin strobe flips the stored output bit, which lets a waveform generator drive the pin without register writes. Peripherals also get the gated pad level before it reaches the synchronizer. Any peripheral that uses it other than as a clock must synchronize it itself.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the direction, output and pull-up registers all read 0. With no override active, pad_oe, pad_out and pad_pu are all 0.
- R2: The register select codes are: bus_addr 0 = direction, 1 = output, 2 = pull-up, 3 = pin readback. A write takes effect at the next clock edge. bus_rdata reflects bus_addr combinationally. A write with bus_addr 3 changes no register.
- R3: For each pin, pad_pu equals pu_ovr_val when pu_ovr_en is 1. Otherwise it equals the pull-up register bit.
- R4: For each pin, pad_oe equals dir_ovr_val when dir_ovr_en is 1. Otherwise it equals the direction register bit.
- R5: For each pin with pad_oe = 1, pad_out equals val_ovr_val when val_ovr_en is 1. Otherwise it equals the output register bit. pad_out is 0 whenever pad_oe is 0.
- R6: Each clock edge at which tgl_ovr is 1 inverts that pin's output register bit once. A write to the output register (bus_addr 1) in the same cycle wins over the toggle.
- R7: A pin's digital input is enabled by din_ovr_val when din_ovr_en is 1. Otherwise it is enabled exactly when core_din_off is 0. A disabled input presents 0.
- R8: periph_din equals the pad level ANDed with the pin's input enable, with no register in the path.
- R9: The pin readback register shows the value of periph_din from two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| core_din_off | input | 8 | Core sleep gating of each pin's input |
| pu_ovr_en | input | 8 | Pull-up override enables |
| pu_ovr_val | input | 8 | Pull-up override values |
| dir_ovr_en | input | 8 | Driver-enable override enables |
| dir_ovr_val | input | 8 | Driver-enable override values |
| val_ovr_en | input | 8 | Output-level override enables |
| val_ovr_val | input | 8 | Output-level override values |
| tgl_ovr | input | 8 | Output-bit toggle strobes |
| din_ovr_en | input | 8 | Input-enable override enables |
| din_ovr_val | input | 8 | Input-enable override values |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output driver enables |
| pad_out | output | 8 | Pad driven levels |
| pad_pu | output | 8 | Pad pull-up enables |
| periph_din | output | 8 | Gated unsynchronized input to peripherals |

## Verification
A corrupted direction, output or pull-up bit shows on pad_oe, pad_out or pad_pu in the same cycle, provided no override masks that pin. It also shows on bus_rdata whenever that register is selected. A lost or doubled toggle leaves the output bit inverted for every later cycle until the next write, so a later readback or driven level exposes it. A fault in the synchronizer shows on the pin readback exactly two edges after the pad changes. The random mix of overrides exercises both the masked and the unmasked state of every pin.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_PIN  = 2'd3
  } reg_sel_e;

  // chosen = override value when enabled, else the base value
  function automatic logic take_over(input logic en, input logic val, input logic base);
    return en ? val : base;
  endfunction

  // next stored output bit: a write wins, otherwise a toggle strobe flips it
  function automatic logic next_out(input logic wr_hit, input logic wbit,
                                    input logic tgl, input logic cur);
    return wr_hit ? wbit : (cur ^ tgl);
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_ovr_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  reg_sel_e        sel,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] tgl,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] pull_q
);

  logic wr_dir, wr_out, wr_pull;
  logic [PINS-1:0] out_d;

  assign wr_dir  = wr && (sel == SEL_DIR);
  assign wr_out  = wr && (sel == SEL_OUT);
  assign wr_pull = wr && (sel == SEL_PULL);

  for (genvar i = 0; i < PINS; i++) begin : g_out
    assign out_d[i] = next_out(wr_out, wdata[i], tgl[i], out_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pull_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_pull) pull_q <= wdata;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/gpio_pin_ovr.sv
module gpio_pin_ovr
  import gpio_ovr_pkg::*;
(
  input  logic dir_bit,
  input  logic out_bit,
  input  logic pull_bit,
  input  logic core_off,
  input  logic pu_en,
  input  logic pu_val,
  input  logic dir_en,
  input  logic dir_val,
  input  logic val_en,
  input  logic val_val,
  input  logic din_en,
  input  logic din_val,
  input  logic pad_lvl,
  output logic oe,
  output logic dout,
  output logic pu,
  output logic in_on,
  output logic din
);

  assign pu    = take_over(pu_en, pu_val, pull_bit);
  assign oe    = take_over(dir_en, dir_val, dir_bit);
  assign dout  = oe & take_over(val_en, val_val, out_bit);
  assign in_on = take_over(din_en, din_val, ~core_off);
  assign din   = pad_lvl & in_on;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] first_q,
  output logic [PINS-1:0] q
);

  logic [STAGES-1:0][PINS-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign first_q = stg[0];
  assign q       = stg[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] core_din_off,
  input  logic [PINS-1:0] pu_ovr_en,
  input  logic [PINS-1:0] pu_ovr_val,
  input  logic [PINS-1:0] dir_ovr_en,
  input  logic [PINS-1:0] dir_ovr_val,
  input  logic [PINS-1:0] val_ovr_en,
  input  logic [PINS-1:0] val_ovr_val,
  input  logic [PINS-1:0] tgl_ovr,
  input  logic [PINS-1:0] din_ovr_en,
  input  logic [PINS-1:0] din_ovr_val,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_pu,
  output logic [PINS-1:0] periph_din
);

  reg_sel_e        sel;
  logic [PINS-1:0] dir_q, out_q, pull_q;
  logic [PINS-1:0] din_on;
  logic [PINS-1:0] sync_first, pin_q;

  assign sel = reg_sel_e'(bus_addr);

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .tgl    (tgl_ovr),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .pull_q (pull_q)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin_ovr u_pin (
      .dir_bit  (dir_q[i]),
      .out_bit  (out_q[i]),
      .pull_bit (pull_q[i]),
      .core_off (core_din_off[i]),
      .pu_en    (pu_ovr_en[i]),
      .pu_val   (pu_ovr_val[i]),
      .dir_en   (dir_ovr_en[i]),
      .dir_val  (dir_ovr_val[i]),
      .val_en   (val_ovr_en[i]),
      .val_val  (val_ovr_val[i]),
      .din_en   (din_ovr_en[i]),
      .din_val  (din_ovr_val[i]),
      .pad_lvl  (pad_in[i]),
      .oe       (pad_oe[i]),
      .dout     (pad_out[i]),
      .pu       (pad_pu[i]),
      .in_on    (din_on[i]),
      .din      (periph_din[i])
    );
  end

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       (periph_din),
    .first_q (sync_first),
    .q       (pin_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR:  bus_rdata = dir_q;
      SEL_OUT:  bus_rdata = out_q;
      SEL_PULL: bus_rdata = pull_q;
      default:  bus_rdata = pin_q;
    endcase
  end

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [PINS-1:0] tgl_ovr,
  input logic [PINS-1:0] dir_ovr_en,
  input logic [PINS-1:0] dir_ovr_val,
  input logic [PINS-1:0] pu_ovr_en,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_pu,
  input logic [PINS-1:0] pull_q,
  input logic [PINS-1:0] out_q,
  input logic [PINS-1:0] din_on,
  input logic [PINS-1:0] periph_din,
  input logic [PINS-1:0] sync_first
);

  // R4
  dir_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & dir_ovr_en) == (dir_ovr_val & dir_ovr_en)));

  // R3
  pull_reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & ~pu_ovr_en) == (pull_q & ~pu_ovr_en)));

  // R5
  no_drive_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd1) |=> (out_q == ($past(out_q) ^ $past(tgl_ovr))));

  // R7
  gated_input_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_din & ~din_on) == '0));

  // R9
  sync_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_first == $past(periph_din)));

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .tgl_ovr     (tgl_ovr),
  .dir_ovr_en  (dir_ovr_en),
  .dir_ovr_val (dir_ovr_val),
  .pu_ovr_en   (pu_ovr_en),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .pad_pu      (pad_pu),
  .pull_q      (pull_q),
  .out_q       (out_q),
  .din_on      (din_on),
  .periph_din  (periph_din),
  .sync_first  (sync_first)
);

// File: tb/sim_gpio_ovr_port.sv
`timescale 1ns/1ps
module sim_gpio_ovr_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] core_din_off = '0;
  logic [7:0] pu_ovr_en = '0, pu_ovr_val = '0, dir_ovr_en = '0, dir_ovr_val = '0;
  logic [7:0] val_ovr_en = '0, val_ovr_val = '0, tgl_ovr = '0;
  logic [7:0] din_ovr_en = '0, din_ovr_val = '0, pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu, periph_din;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_dir = '0, m_out = '0, m_pull = '0, m_s1 = '0, m_s2 = '0;

  always #4 clk = ~clk;

  gpio_ovr_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_din_off(core_din_off),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
    .val_ovr_en(val_ovr_en), .val_ovr_val(val_ovr_val), .tgl_ovr(tgl_ovr),
    .din_ovr_en(din_ovr_en), .din_ovr_val(din_ovr_val), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .periph_din(periph_din)
  );

  function automatic logic [7:0] pick(input logic [7:0] en, input logic [7:0] v,
                                      input logic [7:0] b);
    return (en & v) | (~en & b);
  endfunction

  function automatic logic [7:0] exp_oe();
    return pick(dir_ovr_en, dir_ovr_val, m_dir);
  endfunction

  function automatic logic [7:0] exp_din();
    return pad_in & pick(din_ovr_en, din_ovr_val, ~core_din_off);
  endfunction

  function automatic logic [7:0] exp_rd();
    case (bus_addr)
      2'd0: return m_dir;
      2'd1: return m_out;
      2'd2: return m_pull;
      default: return m_s2;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic step();
    logic [7:0] oe;
    #1;
    oe = exp_oe();
    check("R4 pad_oe", pad_oe, oe);
    check("R3 pad_pu", pad_pu, pick(pu_ovr_en, pu_ovr_val, m_pull));
    check("R5 pad_out", pad_out, oe & pick(val_ovr_en, val_ovr_val, m_out));
    check("R7/R8 periph_din", periph_din, exp_din());
    check(bus_addr == 2'd3 ? "R9 pin readback" : "R2 register read", bus_rdata, exp_rd());
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = exp_din();
    if (bus_wr) begin
      case (bus_addr)
        2'd0: m_dir = bus_wdata;
        2'd2: m_pull = bus_wdata;
        default: ;
      endcase
    end
    // R6: write wins over toggle
    m_out = (bus_wr && bus_addr == 2'd1) ? bus_wdata : (m_out ^ tgl_ovr);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    bus_wr = 0; tgl_ovr = '0; pu_ovr_en = '0; dir_ovr_en = '0;
    val_ovr_en = '0; din_ovr_en = '0; core_din_off = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_set;
    seed_set = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 pad_oe reset", pad_oe, 8'h00);
    check("R1 pad_pu reset", pad_pu, 8'h00);
    check("R1 pad_out reset", pad_out, 8'h00);
    bus_addr = 2'd0; #1 check("R1 dir reset", bus_rdata, 8'h00);
    bus_addr = 2'd1; #1 check("R1 out reset", bus_rdata, 8'h00);
    bus_addr = 2'd2; #1 check("R1 pull reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: directed writes to each register, then read back
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'hA5; step();
    bus_addr = 2'd1; bus_wdata = 8'h3C; step();
    bus_addr = 2'd2; bus_wdata = 8'hF0; step();
    // R2: write to the readback address changes nothing
    bus_addr = 2'd3; bus_wdata = 8'hFF; step();
    bus_wr = 0;
    for (int a = 0; a < 4; a++) begin bus_addr = 2'(a); step(); end

    // R6: toggle alone, then toggle against a same-cycle write
    bus_addr = 2'd1; tgl_ovr = 8'h81; step();
    tgl_ovr = 8'hFF; bus_wr = 1; bus_wdata = 8'h55; step();
    bus_wr = 0; tgl_ovr = '0; step();

    // R7/R9: core gating and input override against a steady pad
    pad_in = 8'hFF; bus_addr = 2'd3; core_din_off = 8'h0F; step();
    din_ovr_en = 8'h03; din_ovr_val = 8'h01; step(); step(); step();
    idle_inputs();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      bus_wr = (r[3:0] < 4'd3);
      bus_addr = r[5:4];
      bus_wdata = 8'($urandom);
      pad_in = 8'($urandom);
      core_din_off = 8'($urandom) & 8'($urandom);
      pu_ovr_en = 8'($urandom) & 8'($urandom); pu_ovr_val = 8'($urandom);
      dir_ovr_en = 8'($urandom) & 8'($urandom); dir_ovr_val = 8'($urandom);
      val_ovr_en = 8'($urandom) & 8'($urandom); val_ovr_val = 8'($urandom);
      din_ovr_en = 8'($urandom) & 8'($urandom); din_ovr_val = 8'($urandom);
      tgl_ovr = 8'($urandom) & 8'($urandom) & 8'($urandom);
      step();
    end
    finish_run();
  end

endmodule